// File: doc/BRIEF.md
# Hart Operating State Controller

This block keeps track of the operating scenario of one processor hart: running, asleep after a wait-for-interrupt instruction, or halted for debug. While the hart runs, the block also follows its privilege level (user, supervisor or machine). It decides whether a retiring WFI may put the hart to sleep. That decision depends on the privilege level the WFI retired in and on the trap-WFI control bit of the machine status register. When the WFI is not permitted, the block raises an illegal-instruction pulse instead of putting the hart to sleep.

A debug halt request is accepted from any privilege level while the hart runs. A halt request that arrives while the hart sleeps is held back and is taken once the hart is running again. On halt entry the privilege level in force is saved. The hart then runs at machine level until a resume strobe restores the saved level. The clock-enable output drops only while the hart sleeps, so a power controller can gate the core clock on it.

Top module: `hart_opstate_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the state is running (code 0), the clock enable is 1, the illegal flag is 0 and the privilege output reads machine (code 3).
- R2: A retiring WFI in machine mode (privilege code 3) while running moves the state to sleeping (code 1) on the next cycle, whatever the trap-WFI bit holds.
- R3: A retiring WFI in supervisor mode (code 1) sleeps when the trap-WFI bit is 0. When the bit is 1, the WFI instead gives a one-cycle illegal pulse and the hart keeps running.
- R4: A retiring WFI in user mode (code 0) or in the reserved level (code 2) never sleeps. It gives a one-cycle illegal pulse on the next cycle and the state stays running.
- R5: While sleeping, the wake input returns the state to running on the next cycle, and the privilege output keeps the value it had when the hart fell asleep.
- R6: While running, a halt request moves the state to halted (code 2) on the next cycle from every privilege level, and the privilege output reads machine while halted.
- R7: A halt request while sleeping is not taken: the state stays sleeping and the clock enable stays 0.
- R8: A halt request seen while sleeping is remembered. The hart enters halted in the cycle after it has returned to running.
- R9: While halted, the resume strobe returns the state to running on the next cycle, with the privilege output equal to the level saved at halt entry.
- R10: The clock enable is 0 exactly while the state is sleeping.
- R11: When a halt request and a retiring WFI arrive in the same running cycle, the halt wins: the next state is halted and no illegal pulse appears.
- R12: A WFI strobe while sleeping or halted has no effect: no illegal pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_retire_i | input | 1 | A WFI instruction retires this cycle |
| priv_i | input | 2 | Current privilege level: 0 user, 1 supervisor, 3 machine |
| trap_wfi_i | input | 1 | Trap-WFI bit of the machine status register |
| wake_i | input | 1 | A pending interrupt asks the hart to wake |
| halt_req_i | input | 1 | Debug halt request |
| resume_i | input | 1 | Debug resume strobe |
| state_o | output | 2 | Operating state: 0 running, 1 sleeping, 2 halted |
| priv_o | output | 2 | Tracked privilege level |
| clk_en_o | output | 1 | Core clock enable, low only while sleeping |
| wfi_illegal_o | output | 1 | One-cycle illegal-instruction pulse for a refused WFI |

## Verification
The embedded assertions check several rules on every cycle. Any entry into sleep must follow a permitted WFI. No halt may follow a sleeping cycle directly. An illegal pulse must come without a state change. Waking must keep the privilege level, halted must always read machine level, and a remembered halt must be taken right after waking. Other behaviours show only in the bench's scenarios. These are the sweep over every privilege level and trap-WFI value, restoring the saved level on resume, and a halt colliding with a WFI. The bench also shows that WFI strobes are ignored outside the running state.

// File: rtl/hart_opstate_pkg.sv
package hart_opstate_pkg;

    localparam int PRIV_W  = 2;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        OP_RUN   = 2'd0,
        OP_SLEEP = 2'd1,
        OP_HALT  = 2'd2
    } op_state_e;

    localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

    typedef struct packed {
        op_state_e         st;
        logic [PRIV_W-1:0] priv;
        logic [PRIV_W-1:0] save;
        logic              illegal;
    } opstate_regs_t;

endpackage

// File: rtl/wfi_gate.sv
module wfi_gate
    import hart_opstate_pkg::*;
(
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              trap_wfi_i,
    output logic              permit_o
);

    // Machine level always may sleep; supervisor only without the trap bit.
    always_comb begin
        permit_o = 1'b0;
        if (priv_i == PRIV_M) begin
            permit_o = 1'b1;
        end else if (priv_i == PRIV_S) begin
            permit_o = !trap_wfi_i;
        end
    end

endmodule

// File: rtl/halt_pend.sv
module halt_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_d;
    logic pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) begin
            pend_d = 1'b0;
        end
        if (set_i) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/opstate_fsm.sv
module opstate_fsm
    import hart_opstate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wfi_i,
    input  logic              wfi_ok_i,
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              wake_i,
    input  logic              halt_req_i,
    input  logic              pend_i,
    input  logic              resume_i,
    output op_state_e         state_o,
    output logic [PRIV_W-1:0] priv_o,
    output logic              illegal_o,
    output logic              take_o,
    output logic              sleeping_o
);

    opstate_regs_t r_d;
    opstate_regs_t r_q;

    always_comb begin
        r_d         = r_q;
        r_d.illegal = 1'b0;
        take_o      = 1'b0;
        unique case (r_q.st)
            OP_RUN: begin
                r_d.priv = priv_i;
                if (halt_req_i || pend_i) begin
                    take_o   = 1'b1;
                    r_d.st   = OP_HALT;
                    r_d.save = priv_i;
                    r_d.priv = PRIV_M;
                end else if (wfi_i) begin
                    if (wfi_ok_i) begin
                        r_d.st = OP_SLEEP;
                    end else begin
                        r_d.illegal = 1'b1;
                    end
                end
            end
            OP_SLEEP: begin
                if (wake_i) begin
                    r_d.st = OP_RUN;
                end
            end
            OP_HALT: begin
                if (resume_i) begin
                    r_d.st   = OP_RUN;
                    r_d.priv = r_q.save;
                end
            end
            default: begin
                r_d.st = OP_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= OP_RUN;
            r_q.priv    <= PRIV_M;
            r_q.save    <= PRIV_M;
            r_q.illegal <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.st;
    assign priv_o     = r_q.priv;
    assign illegal_o  = r_q.illegal;
    assign sleeping_o = (r_q.st == OP_SLEEP);

    AST_SLEEP_NEEDS_LEGAL_WFI: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OP_SLEEP && $past(r_q.st) != OP_SLEEP) |-> ($past(wfi_i) && $past(wfi_ok_i))); // R4
    AST_NO_HALT_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == OP_SLEEP) |-> (r_q.st != OP_HALT)); // R7
    AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (r_q.st == $past(r_q.st))); // R3
    AST_WAKE_KEEPS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OP_RUN && $past(r_q.st) == OP_SLEEP) |-> (priv_o == $past(priv_o))); // R5
    AST_HALT_AT_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OP_HALT) |-> (priv_o == PRIV_M)); // R6

endmodule

// File: rtl/hart_opstate_ctrl.sv
module hart_opstate_ctrl
    import hart_opstate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wfi_retire_i,
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              trap_wfi_i,
    input  logic              wake_i,
    input  logic              halt_req_i,
    input  logic              resume_i,
    output logic [STATE_W-1:0] state_o,
    output logic [PRIV_W-1:0] priv_o,
    output logic              clk_en_o,
    output logic              wfi_illegal_o
);

    logic      wfi_ok;
    logic      pend;
    logic      take;
    logic      sleeping;
    op_state_e st;

    wfi_gate u_gate (
        .priv_i     (priv_i),
        .trap_wfi_i (trap_wfi_i),
        .permit_o   (wfi_ok)
    );

    halt_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (halt_req_i && sleeping),
        .clr_i  (take),
        .pend_o (pend)
    );

    opstate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_i      (wfi_retire_i),
        .wfi_ok_i   (wfi_ok),
        .priv_i     (priv_i),
        .wake_i     (wake_i),
        .halt_req_i (halt_req_i),
        .pend_i     (pend),
        .resume_i   (resume_i),
        .state_o    (st),
        .priv_o     (priv_o),
        .illegal_o  (wfi_illegal_o),
        .take_o     (take),
        .sleeping_o (sleeping)
    );

    assign state_o  = st;
    assign clk_en_o = !sleeping;

    AST_PENDING_HALT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_RUN && $past(st) == OP_SLEEP && pend) |=> (st == OP_HALT)); // R8
    AST_CLKEN_ONLY_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o) |-> (state_o == 2'd1)); // R10

endmodule

// File: tb/sim_hart_opstate_ctrl.sv
module sim_hart_opstate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi = 1'b0;
    logic [1:0] priv = 2'd3;
    logic       tw = 1'b0;
    logic       wake = 1'b0;
    logic       halt = 1'b0;
    logic       resume = 1'b0;
    logic [1:0] state;
    logic [1:0] priv_o;
    logic       clk_en;
    logic       illegal;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    hart_opstate_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wfi_retire_i  (wfi),
        .priv_i        (priv),
        .trap_wfi_i    (tw),
        .wake_i        (wake),
        .halt_req_i    (halt),
        .resume_i      (resume),
        .state_o       (state),
        .priv_o        (priv_o),
        .clk_en_o      (clk_en),
        .wfi_illegal_o (illegal)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wfi = 0; wake = 0; halt = 0; resume = 0; tw = 0; priv = 2'd3;
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        step();
        // R1 reset values
        chk("R1 state", state, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 illegal", illegal, 0);
        chk("R1 priv", priv_o, 3);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 R5 R10: sweep every privilege and trap-WFI value
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 2; t++) begin
                bit ok;
                do_reset();
                ok = (p == 3) || (p == 1 && t == 0);
                priv = 2'(p); tw = t[0];
                step();
                wfi = 1'b1;
                step();
                wfi = 1'b0;
                chk(ok ? "R2/R3 sleep state" : "R3/R4 refused state", state, ok ? 1 : 0);
                chk("R3/R4 illegal pulse", illegal, ok ? 0 : 1);
                chk("R10 clk_en", clk_en, ok ? 0 : 1);
                step();
                chk("R4 pulse one cycle", illegal, 0);
                if (ok) begin
                    priv = 2'(3 - p);
                    wfi = 1'b1;          // R12 WFI while sleeping
                    step();
                    wfi = 1'b0;
                    chk("R12 no illegal in sleep", illegal, 0);
                    chk("R12 stays asleep", state, 1);
                    wake = 1'b1;
                    step();
                    wake = 1'b0;
                    chk("R5 woken state", state, 0);
                    chk("R5 priv kept", priv_o, p);
                    chk("R10 clk_en after wake", clk_en, 1);
                end
            end
        end

        // R6 R9 R12: halt from every privilege, resume restores it
        for (int p = 0; p < 4; p++) begin
            do_reset();
            priv = 2'(p);
            step();
            halt = 1'b1;
            step();
            halt = 1'b0;
            chk("R6 halted", state, 2);
            chk("R6 priv machine", priv_o, 3);
            priv = 2'(p ^ 1);
            wfi = 1'b1;
            step();
            wfi = 1'b0;
            chk("R12 no illegal in halt", illegal, 0);
            chk("R12 stays halted", state, 2);
            resume = 1'b1;
            step();
            resume = 1'b0;
            chk("R9 resumed", state, 0);
            chk("R9 priv restored", priv_o, p);
        end

        // R7 R8: halt during sleep is deferred
        do_reset();
        wfi = 1'b1;
        step();
        wfi = 1'b0;
        halt = 1'b1;
        step();
        halt = 1'b0;
        chk("R7 still asleep", state, 1);
        chk("R7 clk_en low", clk_en, 0);
        step();
        chk("R7 still asleep later", state, 1);
        wake = 1'b1;
        step();
        wake = 1'b0;
        chk("R8 running after wake", state, 0);
        step();
        chk("R8 deferred halt taken", state, 2);
        resume = 1'b1;
        step();
        resume = 1'b0;
        chk("R8 resumed", state, 0);
        step();
        chk("R8 no repeat halt", state, 0);

        // R11: halt and WFI collide
        for (int p = 0; p < 4; p += 3) begin
            do_reset();
            priv = 2'(p);
            step();
            wfi = 1'b1; halt = 1'b1;
            step();
            wfi = 1'b0; halt = 1'b0;
            chk("R11 halt wins", state, 2);
            chk("R11 no illegal", illegal, 0);
            chk("R11 clk_en", clk_en, 1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule